// File: doc/BRIEF.md
# Multichannel Pulse-Width Modulator with Atomic Register Aliases

This block drives a parameterised number of pulse-width modulated pins from a small memory-mapped register file. Each channel owns a period register, which holds the period count, the clock divider code and the two output state codes, and an active-window register, which holds the count where the active phase starts and the count where it stops. A shared control word enables channels one bit at a time. Every register can be changed atomically: besides a plain write, three alias addresses per register OR, clear or XOR the written data into the stored value.

Each channel runs a small state machine with three named states. `CH_IDLE` holds the counter and the prescaler at zero and leaves the pin released. Setting the channel's enable bit takes the transition *start*: the working copies of both registers are loaded, the count is zero, and the machine moves to `CH_ACT` or `CH_INACT`, whichever the count falls in. On each prescaled tick the transition *advance* raises the count, and *wrap* (the count equals the period) returns it to zero and reloads the working copies. After either one the state is `CH_ACT` when start ≤ count < stop and `CH_INACT` otherwise. Clearing the enable bit takes the transition *stop* back to `CH_IDLE` from either running state. The pin follows the 2-bit state code of the current phase.

Top module: `pwm_multi`

## Requirements
- R1: After a synchronous reset every register reads 0 and every pin is released (`pwm_oe` = 0, `pwm_do` = 0).
- R2: A write to a register's base address stores the data. A read of the base address or of any of its aliases returns the last stored value. A read of an unmapped address returns 0. The control word is at 0x00, the active window of channel n at 0x10 + 0x20·n and the period of channel n at 0x20 + 0x20·n.
- R3: A write to base+0x4 ORs the data into the register, base+0x8 clears the bits set in the data, and base+0xC XORs the data into it.
- R4: Control bit n enables channel n. A disabled channel keeps its pin released and its counter at zero, and other channels are unaffected by it.
- R5: Period register bits [15:0] give P. The counter counts 0..P in prescaled ticks and then wraps, so one period lasts P+1 ticks.
- R6: Active-window bits [15:0] give the start and bits [31:16] give the stop. The channel is in its active phase while start ≤ count < stop and in its inactive phase otherwise.
- R7: Period bits [17:16] give the active-phase state code and bits [19:18] the inactive-phase code. Codes 0 and 1 release the pin (oe 0, data 0), code 2 drives 0 and code 3 drives 1.
- R8: Period bits [22:20] select the divider: codes 0..7 divide by 1, 2, 4, 8, 16, 64, 256 and 1024.
- R9: New period and window values take effect only at a wrap. The period in progress completes with the old values.
- R10: When a channel is enabled with start 0, its pin shows the active state in the second cycle after the enabling write and the count begins at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_oe | output | NCH | Per-channel pin drive enable |
| pwm_do | output | NCH | Per-channel pin data |

## Verification
The alias checks use overlapping bit patterns, so OR, clear and XOR each give a different result from a plain write. The waveform is measured with the period, window and divider varied separately: rise-to-rise distance isolates the period and the divider, and high-cycle counts isolate the window. Inverted and releasing state codes show that the pin follows the phase codes rather than a fixed polarity. A period change written just after a wrap separates shadowed loading from immediate loading. Re-enabling a channel after a stop shows that the count restarts from zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ACT   = 2'd1,
        CH_INACT = 2'd2
    } ch_state_t;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } wr_op_t;

    localparam int PRE_W = 10;

    // Terminal value of the prescaler counter for each divider code
    function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] code);
        logic [PRE_W-1:0] lim;
        unique case (code)
            3'd0:    lim = 10'd0;
            3'd1:    lim = 10'd1;
            3'd2:    lim = 10'd3;
            3'd3:    lim = 10'd7;
            3'd4:    lim = 10'd15;
            3'd5:    lim = 10'd63;
            3'd6:    lim = 10'd255;
            default: lim = 10'd1023;
        endcase
        return lim;
    endfunction

    function automatic logic [31:0] apply_op(input wr_op_t op, input logic [31:0] cur,
                                             input logic [31:0] din);
        logic [31:0] res;
        unique case (op)
            OP_WRITE: res = din;
            OP_SET:   res = cur | din;
            OP_CLR:   res = cur & ~din;
            default:  res = cur ^ din;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [31:0]            ctrl_q,
    output logic [NCH-1:0][31:0]   win_q,
    output logic [NCH-1:0][31:0]   per_q
);
    localparam int IDX_W = ADDR_W - 5;

    wr_op_t           op;
    logic [IDX_W-1:0] idx;
    logic             hit_ctrl;
    logic [NCH-1:0]   hit_win;
    logic [NCH-1:0]   hit_per;

    assign op       = wr_op_t'(addr[3:2]);
    assign idx      = addr[ADDR_W-1:5];
    assign hit_ctrl = (idx == '0) && !addr[4];

    always_ff @(posedge clk) begin
        if (rst)                  ctrl_q <= '0;
        else if (wr && hit_ctrl)  ctrl_q <= apply_op(op, ctrl_q, wdata);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chreg
        assign hit_win[g] = addr[4]  && (idx == IDX_W'(g));
        assign hit_per[g] = !addr[4] && (idx == IDX_W'(g + 1));

        always_ff @(posedge clk) begin
            if (rst)                    win_q[g] <= '0;
            else if (wr && hit_win[g])  win_q[g] <= apply_op(op, win_q[g], wdata);
        end

        always_ff @(posedge clk) begin
            if (rst)                    per_q[g] <= '0;
            else if (wr && hit_per[g])  per_q[g] <= apply_op(op, per_q[g], wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) rdata = ctrl_q;
        for (int i = 0; i < NCH; i++) begin
            if (hit_win[i]) rdata = win_q[i];
            if (hit_per[i]) rdata = per_q[i];
        end
    end

    p_set_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && hit_ctrl && op == OP_SET) |=> ctrl_q == ($past(ctrl_q) | $past(wdata)));
    p_clr_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && hit_ctrl && op == OP_CLR) |=> ctrl_q == ($past(ctrl_q) & ~$past(wdata)));
    p_tog_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && hit_ctrl && op == OP_TOG) |=> ctrl_q == ($past(ctrl_q) ^ $past(wdata)));
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr && hit_ctrl) |=> $stable(ctrl_q));

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    logic [PRE_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q == div_limit(code));

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt_q <= '0;
        else if (tick)   pcnt_q <= '0;
        else             pcnt_q <= pcnt_q + 1'b1;
    end

    p_pre_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !run |=> pcnt_q == '0);
    p_pre_bound_r8: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= div_limit(code));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] per_reg,
    input  logic [31:0] win_reg,
    output logic        pin_oe,
    output logic        pin_do
);
    ch_state_t   state_q, state_n;
    logic [15:0] cnt_q, cnt_n;
    logic [31:0] wper_q, wper_n;
    logic [31:0] wwin_q, wwin_n;
    logic        tick;
    logic        wrap;
    logic [1:0]  code;
    logic        unused_hi;

    assign unused_hi = ^wper_q[31:23];
    assign wrap      = tick && (cnt_q == wper_q[15:0]);

    pwm_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (en && (state_q != CH_IDLE)),
        .code (wper_q[22:20]),
        .tick (tick)
    );

    function automatic ch_state_t phase_of(input logic [15:0] c, input logic [31:0] w);
        return (c >= w[15:0] && c < w[31:16]) ? CH_ACT : CH_INACT;
    endfunction

    // next-state: start, advance, wrap, stop
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        wper_n  = wper_q;
        wwin_n  = wwin_q;
        unique case (state_q)
            CH_IDLE: begin
                if (en) begin
                    wper_n  = per_reg;
                    wwin_n  = win_reg;
                    cnt_n   = '0;
                    state_n = phase_of(16'd0, win_reg);
                end
            end
            CH_ACT, CH_INACT: begin
                if (!en) begin
                    cnt_n   = '0;
                    state_n = CH_IDLE;
                end else if (tick) begin
                    if (wrap) begin
                        cnt_n  = '0;
                        wper_n = per_reg;
                        wwin_n = win_reg;
                    end else begin
                        cnt_n  = cnt_q + 1'b1;
                    end
                    state_n = phase_of(cnt_n, wwin_n);
                end
            end
            default: begin
                cnt_n   = '0;
                state_n = CH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            wper_q  <= '0;
            wwin_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            wper_q  <= wper_n;
            wwin_q  <= wwin_n;
        end
    end

    // outputs from the current phase
    always_comb begin
        unique case (state_q)
            CH_ACT:   code = wper_q[17:16];
            CH_INACT: code = wper_q[19:18];
            default:  code = 2'd0;
        endcase
        pin_oe = code[1];
        pin_do = code[1] & code[0];
    end

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == 16'd0 && !pin_oe));
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q != CH_IDLE) |-> cnt_q <= wper_q[15:0]);
    p_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q != CH_IDLE && en && tick && !wrap) |=> cnt_q == $past(cnt_q) + 16'd1);
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q != CH_IDLE && en && !wrap) |=> ($stable(wper_q) && $stable(wwin_q)));
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> !pin_do);

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = $clog2(32 * (NCH + 1))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_oe,
    output logic [NCH-1:0]    pwm_do
);
    logic [31:0]          ctrl_q;
    logic [NCH-1:0][31:0] win_q;
    logic [NCH-1:0][31:0] per_q;
    logic                 unused_ctrl;

    assign unused_ctrl = ^ctrl_q[31:NCH];

    pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_q (ctrl_q),
        .win_q  (win_q),
        .per_q  (per_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .en      (ctrl_q[g]),
            .per_reg (per_q[g]),
            .win_reg (win_q[g]),
            .pin_oe  (pwm_oe[g]),
            .pin_do  (pwm_do[g])
        );
    end

endmodule

// File: tb/pwm_multi_bench.sv
module pwm_multi_bench;
    localparam int NCH    = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    pwm_oe;
    logic [NCH-1:0]    pwm_do;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;

    pwm_multi #(.NCH(NCH)) u_pwm_multi (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_oe(pwm_oe), .pwm_do(pwm_do)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] a_win(input int ch); return 8'(16 + 32 * ch); endfunction
    function automatic logic [7:0] a_per(input int ch); return 8'(32 + 32 * ch); endfunction
    function automatic logic [31:0] per_word(input int p, input int act, input int inact, input int dv);
        return 32'(p) | (32'(act) << 16) | (32'(inact) << 18) | (32'(dv) << 20);
    endfunction
    function automatic logic [31:0] win_word(input int start, input int stop);
        return 32'(start) | (32'(stop) << 16);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    function automatic logic sample(input int ch, input bit oe_only);
        return oe_only ? pwm_oe[ch] : (pwm_oe[ch] & pwm_do[ch]);
    endfunction

    task automatic wait_rise(input int ch, input bit oe_only, output longint stamp);
        logic prev;
        prev = sample(ch, oe_only);
        stamp = -1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (sample(ch, oe_only) && !prev) begin
                stamp = cyc;
                return;
            end
            prev = sample(ch, oe_only);
        end
        check(1'b0, "rise timeout", 0, 1);
    endtask

    // interval between two rises and high samples within it
    task automatic measure(input int ch, input bit oe_only, output longint n, output int highs,
                           output bit do_seen);
        longint s0;
        logic prev;
        wait_rise(ch, oe_only, s0);
        highs = 1; n = 0; do_seen = pwm_do[ch];
        prev = 1'b1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            n++;
            if (sample(ch, oe_only) && !prev) return;
            if (sample(ch, oe_only)) highs++;
            if (pwm_do[ch]) do_seen = 1'b1;
            prev = sample(ch, oe_only);
        end
        check(1'b0, "measure timeout", 0, 1);
    endtask

    task automatic t_reset();
        rd_check(8'h00, 32'h0, "R1 ctrl after reset");
        rd_check(a_win(0), 32'h0, "R1 win0 after reset");
        rd_check(a_per(3), 32'h0, "R1 per3 after reset");
        check(pwm_oe == '0 && pwm_do == '0, "R1 pins released", pwm_oe, 0);
    endtask

    task automatic t_regs();
        wr(a_per(1), 32'h1234_5678);
        rd_check(a_per(1), 32'h1234_5678, "R2 per1 readback");
        wr(a_win(2), 32'hCAFE_0001);
        rd_check(a_win(2), 32'hCAFE_0001, "R2 win2 readback");
        rd_check(a_per(1) + 8'h4, 32'h1234_5678, "R2 alias read returns base");
        rd_check(8'h90, 32'h0, "R2 unmapped read");
        rd_check(a_per(0), 32'h0, "R2 neighbour untouched");
    endtask

    task automatic t_alias();
        wr(a_per(2), 32'h0000_0050);
        wr(a_per(2) + 8'h4, 32'h0000_000A);
        rd_check(a_per(2), 32'h0000_005A, "R3 set alias");
        wr(a_per(2) + 8'h8, 32'h0000_0012);
        rd_check(a_per(2), 32'h0000_0048, "R3 clear alias");
        wr(a_per(2) + 8'hC, 32'h0000_00FF);
        rd_check(a_per(2), 32'h0000_00B7, "R3 toggle alias");
        wr(8'h00, 32'hA0);
        wr(8'h0C, 32'hF0);
        rd_check(8'h00, 32'h50, "R3 toggle on ctrl");
        wr(8'h00, 32'h0);
        check(pwm_oe == '0, "R4 disabled pins released", pwm_oe, 0);
    endtask

    task automatic t_start();
        wr(a_per(0), per_word(7, 3, 2, 0));
        wr(a_win(0), win_word(0, 3));
        wr(8'h04, 32'h1);
        @(posedge clk); @(negedge clk);
        check(pwm_oe[0] && pwm_do[0], "R10 active in second cycle", {pwm_oe[0], pwm_do[0]}, 3);
        @(negedge clk);
        check(pwm_oe[0] && pwm_do[0], "R10 active cnt1", pwm_do[0], 1);
        @(negedge clk);
        check(pwm_oe[0] && pwm_do[0], "R10 active cnt2", pwm_do[0], 1);
        @(negedge clk);
        check(pwm_oe[0] && !pwm_do[0], "R7 inactive drives low", pwm_do[0], 0);
        check(pwm_oe[3:1] == 3'b000, "R4 other channels released", pwm_oe[3:1], 0);
    endtask

    task automatic t_duty();
        longint n; int h; bit d;
        measure(0, 1'b0, n, h, d);
        check(n == 8, "R5 period P=7", n, 8);
        check(h == 3, "R6 window 0..3", h, 3);
        wr(a_win(0), win_word(2, 5));
        measure(0, 1'b0, n, h, d);
        measure(0, 1'b0, n, h, d);
        check(n == 8, "R6 shifted window period", n, 8);
        check(h == 3, "R6 window 2..5", h, 3);
    endtask

    task automatic t_codes();
        longint n; int h; bit d;
        wr(a_win(0), win_word(0, 3));
        wr(a_per(0), per_word(7, 2, 1, 0));
        measure(0, 1'b1, n, h, d);
        measure(0, 1'b1, n, h, d);
        check(h == 3, "R7 code2 drives, code1 releases", h, 3);
        check(d == 1'b0, "R7 code2 data low", d, 0);
        check(n == 8, "R7 period under codes", n, 8);
        wr(a_per(0), per_word(7, 3, 2, 0));
    endtask

    task automatic t_div();
        longint s0, s1, s2;
        for (int code = 0; code < 8; code++) begin
            int dv;
            dv = (code < 5) ? (1 << code) : (1 << (2 * code - 4));
            wr(a_win(0), win_word(0, 1));
            wr(a_per(0), per_word(1, 3, 2, code));
            wait_rise(0, 1'b0, s0);
            wait_rise(0, 1'b0, s1);
            wait_rise(0, 1'b0, s2);
            check((s2 - s1) == 2 * dv, $sformatf("R8 divider code %0d", code), s2 - s1, 2 * dv);
        end
        wr(a_per(0), per_word(7, 3, 2, 0));
        wr(a_win(0), win_word(0, 3));
    endtask

    task automatic t_shadow();
        longint s0, s1, s2;
        wait_rise(0, 1'b0, s0);
        wait_rise(0, 1'b0, s0);
        wr(a_per(0), per_word(11, 3, 2, 0));
        wait_rise(0, 1'b0, s1);
        wait_rise(0, 1'b0, s2);
        check((s1 - s0) == 8, "R9 old period completes", s1 - s0, 8);
        check((s2 - s1) == 12, "R9 new period after wrap", s2 - s1, 12);
    endtask

    task automatic t_multi();
        longint n; int h; bit d;
        wr(a_per(2), per_word(4, 3, 2, 1));
        wr(a_win(2), win_word(0, 2));
        wr(8'h04, 32'h4);
        measure(2, 1'b0, n, h, d);
        check(n == 10, "R4 channel2 independent period", n, 10);
        check(h == 4, "R8 channel2 high cycles", h, 4);
        measure(0, 1'b0, n, h, d);
        check(n == 12, "R4 channel0 unaffected", n, 12);
    endtask

    task automatic t_stop_restart();
        wr(8'h08, 32'h1);
        @(posedge clk); @(negedge clk);
        check(!pwm_oe[0], "R4 disabled channel released", pwm_oe[0], 0);
        repeat (5) @(negedge clk);
        check(!pwm_oe[0] && pwm_oe[2], "R4 stays released, ch2 runs", {pwm_oe[0], pwm_oe[2]}, 1);
        wr(a_per(0), per_word(7, 3, 2, 0));
        wr(8'h04, 32'h1);
        @(posedge clk); @(negedge clk);
        check(pwm_do[0], "R10 restart active", pwm_do[0], 1);
        @(negedge clk); @(negedge clk); @(negedge clk);
        check(pwm_oe[0] && !pwm_do[0], "R10 count restarted at zero", pwm_do[0], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_alias();
        t_start();
        t_duty();
        t_codes();
        t_div();
        t_shadow();
        t_multi();
        t_stop_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule